// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block walks a hashed page table held in memory to find the translation for one virtual page. The caller supplies a compare tag (virtual segment identifier and abbreviated page index, already packed), a hash value, the table base address and size mask, the protection key bit, the no-execute flag and the kind of access. The block derives the address of an eight-entry group from the hash, reads the two words of each entry over a simple request/valid read port, and stops at the first entry that is valid, was placed by the matching hash function and carries the same tag.

If no entry in the primary group matches, the search is repeated once over the secondary group, found from the bitwise complement of the hash. On a match the block evaluates the page protection bits against the key, the no-execute flag and the access kind. It marks the entry referenced and, for a permitted write, changed, and writes the second word back when it changed. It returns the real page number, the granted rights and a status. A page that has not been written yet is reported without write permission to any access other than a permitted write, so that the first store to it comes back through the searcher and sets the changed bit.

Top module: `ptg_searcher`

## Requirements
- R1: The group address is `tbl_base + ((hash << 6) & tbl_mask)` with the hash zero-extended to 32 bits. Entry i's word 0 is read at group+8i and word 1 at group+8i+4, and the slots are visited in the order 0 to 7.
- R2: An entry matches only when word 0 bit 31 (valid) is 1, word 0 bit 6 (hash select) equals the pass (0 primary, 1 secondary), and `(word0 & 32'h7FFFFFBF) == tag_in`.
- R3: The first matching entry in slot order ends the search. Later entries are not used.
- R4: A secondary pass over the group of `~hash` (19 bits) runs only when no primary entry matched.
- R5: When neither pass matches, `status` is 1 (not found), `rights_out` is 0 and `rpn_out` is 0, and nothing is written.
- R6: `rights_out` is {exec, write, read} in bits 2:0, with pp = word 1 bits 1:0. With key 0, pp 0 to 2 give read+write and pp 3 gives read. With key 1, pp 0 gives nothing, pp 2 gives read+write, and pp 1 or 3 give read. Exec is granted exactly when `nx_in` is 0.
- R7: For `acc_kind` 0 (read), 1 (write) or 2 (fetch), `status` is 0 (ok) when the read, write or exec right respectively is granted, and 2 (protection fault) otherwise.
- R8: On any match the referenced bit (word 1 bit 8) is set in the written-back word.
- R9: The changed bit (word 1 bit 7) is set only for a permitted write. If it was clear and the access is not a permitted write, the write right is removed from `rights_out`.
- R10: Word 1 is written back to entry address +4 with one `wr_req` cycle exactly when its new value differs from the old one. Otherwise no write occurs.
- R11: After reset `busy`, `done`, `rd_req` and `wr_req` are 0. A `start` while idle sets `busy` until a one-cycle `done`, and the results hold until the next `start`.
- R12: On a match `rpn_out` is word 1 bits 31:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (taken when idle) |
| tag_in | input | 32 | Packed compare tag |
| hash_in | input | 19 | Primary hash |
| tbl_base | input | 32 | Page table base address |
| tbl_mask | input | 32 | Page table offset mask |
| key_in | input | 1 | Protection key bit |
| nx_in | input | 1 | No-execute flag |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 not found, 2 protection fault |
| rpn_out | output | 20 | Real page number |
| rights_out | output | 3 | {exec, write, read} |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | 32 | Read byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | One-cycle write strobe |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |

## Verification
Each word read completes on the first rising edge where `rd_valid` is high, so the search length depends on memory latency. The bench's memory model inserts 0 to 2 random wait cycles per word. Once the last needed word arrives, the entry is judged on the next cycle. A changed word 1 is written on the cycle after that, and `done` rises one cycle after the judgement or one cycle after the write. The bench therefore waits on `done` at falling edges rather than counting cycles, samples `status`, `rpn_out` and `rights_out` in that cycle, and checks a few cycles later that they are still held. It inspects memory for the write-back only after `done`, because the write always precedes `done` by exactly one cycle.

// File: rtl/ptg_pkg.sv
// Shared constants and types for the page table group searcher.
// Assumes 32-bit entry words, two words per entry.
package ptg_pkg;
    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_MISS = 2'd1,
        ST_PROT = 2'd2
    } srch_status_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    localparam int          WORD_W    = 32;
    localparam logic [31:0] TAG_MASK  = 32'h7FFF_FFBF;
    localparam int          VALID_POS = 31;
    localparam int          HSEL_POS  = 6;
    localparam int          REF_POS   = 8;
    localparam int          CHG_POS   = 7;
endpackage

// File: rtl/ptg_addr_gen.sv
// Address generator: forms the byte address of one entry word.
// Assumes a group is SLOTS entries of 8 bytes; the base is group aligned.
module ptg_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int HASH_W = 19,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic [HASH_W-1:0] hash,
    input  logic              pass,
    input  logic [IDX_W-1:0]  idx,
    input  logic              word_sel,
    output logic [ADDR_W-1:0] addr
);
    localparam int GRP_SHIFT = IDX_W + 3;

    logic [HASH_W-1:0] hash_eff;
    logic [ADDR_W-1:0] grp_off;
    logic [ADDR_W-1:0] ent_off;

    // Pick the hash for this pass and build group and entry offsets.
    always_comb begin
        hash_eff = pass ? ~hash : hash;
        grp_off  = (ADDR_W'(hash_eff) << GRP_SHIFT) & mask;
        ent_off  = ADDR_W'({idx, word_sel, 2'b00});
        addr     = base + grp_off + ent_off;
    end
endmodule

// File: rtl/ptg_entry_match.sv
// Entry matcher: decides whether word 0 of an entry hits the tag.
// Assumes the tag already has the hash-select and valid positions clear.
module ptg_entry_match
    import ptg_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] tag,
    input  logic              pass,
    output logic              hit
);
    // Valid, placed by this pass's hash, and same tag.
    always_comb begin
        hit = word0[VALID_POS] && (word0[HSEL_POS] == pass) &&
              ((word0 & TAG_MASK) == tag);
    end
endmodule

// File: rtl/ptg_rights.sv
// Rights evaluator: turns pp, key and nx into rights, judges the access
// and forms the updated word 1 with referenced/changed bits.
module ptg_rights
    import ptg_pkg::*;
(
    input  logic              key,
    input  logic              nx,
    input  logic [1:0]        kind,
    input  logic [WORD_W-1:0] word1,
    output logic [2:0]        rights,
    output logic              allowed,
    output logic [WORD_W-1:0] new_word1,
    output logic              wb_need
);
    logic rd_ok, wr_ok, ex_ok;

    // Decode the protection field against the key.
    always_comb begin
        rd_ok = 1'b1;
        wr_ok = 1'b0;
        unique case ({key, word1[1:0]})
            3'b000, 3'b001, 3'b010: wr_ok = 1'b1;
            3'b011:                 wr_ok = 1'b0;
            3'b100:                 rd_ok = 1'b0;
            3'b110:                 wr_ok = 1'b1;
            default:                wr_ok = 1'b0;
        endcase
        ex_ok = ~nx;
    end

    // Judge the access and form the flag update.
    always_comb begin
        unique case (kind)
            ACC_WRITE: allowed = wr_ok;
            ACC_FETCH: allowed = ex_ok;
            default:   allowed = rd_ok;
        endcase
        new_word1          = word1;
        new_word1[REF_POS] = 1'b1;
        rights             = {ex_ok, wr_ok, rd_ok};
        if (!word1[CHG_POS]) begin
            if (kind == ACC_WRITE && allowed) new_word1[CHG_POS] = 1'b1;
            else                              rights[1] = 1'b0;
        end
        wb_need = (new_word1 != word1);
    end
endmodule

// File: rtl/ptg_searcher.sv
// Page table group searcher: two-pass search of eight-entry groups,
// flag write-back and rights/status report.
// Assumes the memory answers each held rd_req with one rd_valid cycle and
// accepts a wr_req strobe in the cycle it is given.
module ptg_searcher
    import ptg_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int HASH_W     = 19,
    parameter int SLOTS      = 8,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [31:0]              tag_in,
    input  logic [HASH_W-1:0]        hash_in,
    input  logic [ADDR_W-1:0]        tbl_base,
    input  logic [ADDR_W-1:0]        tbl_mask,
    input  logic                     key_in,
    input  logic                     nx_in,
    input  logic [1:0]               acc_kind,
    output logic                     busy,
    output logic                     done,
    output logic [1:0]               status,
    output logic [31-PAGE_SHIFT:0]   rpn_out,
    output logic [2:0]               rights_out,
    output logic                     rd_req,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic                     rd_valid,
    input  logic [31:0]              rd_data,
    output logic                     wr_req,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [31:0]              wr_data
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int RPN_W = WORD_W - PAGE_SHIFT;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_CHK, S_WB, S_FIN} state_e;

    state_e            state_q;
    logic              pass_q;
    logic [IDX_W-1:0]  idx_q;
    logic [31:0]       w0_q, w1_q, wb_data_q;
    logic [31:0]       tag_q;
    logic [HASH_W-1:0] hash_q;
    logic [ADDR_W-1:0] base_q, mask_q;
    logic              key_q, nx_q;
    logic [1:0]        kind_q;
    logic [1:0]        status_q;
    logic [RPN_W-1:0]  rpn_q;
    logic [2:0]        rights_q;

    logic [ADDR_W-1:0] ent_addr;
    logic              hit;
    logic [2:0]        rt_rights;
    logic              rt_allowed, rt_wb;
    logic [31:0]       rt_new_w1;

    ptg_addr_gen #(.ADDR_W(ADDR_W), .HASH_W(HASH_W), .IDX_W(IDX_W)) addr_i (
        .base(base_q), .mask(mask_q), .hash(hash_q), .pass(pass_q),
        .idx(idx_q), .word_sel(state_q != S_RD0), .addr(ent_addr)
    );

    ptg_entry_match match_i (
        .word0(w0_q), .tag(tag_q), .pass(pass_q), .hit(hit)
    );

    ptg_rights rights_i (
        .key(key_q), .nx(nx_q), .kind(kind_q), .word1(w1_q),
        .rights(rt_rights), .allowed(rt_allowed),
        .new_word1(rt_new_w1), .wb_need(rt_wb)
    );

    // Search sequencer: fetch, judge, step slots and passes, write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            pass_q    <= 1'b0;
            idx_q     <= '0;
            w0_q      <= '0;
            w1_q      <= '0;
            wb_data_q <= '0;
            tag_q     <= '0;
            hash_q    <= '0;
            base_q    <= '0;
            mask_q    <= '0;
            key_q     <= 1'b0;
            nx_q      <= 1'b0;
            kind_q    <= ACC_READ;
            status_q  <= ST_OK;
            rpn_q     <= '0;
            rights_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    tag_q   <= tag_in;
                    hash_q  <= hash_in;
                    base_q  <= tbl_base;
                    mask_q  <= tbl_mask;
                    key_q   <= key_in;
                    nx_q    <= nx_in;
                    kind_q  <= acc_kind;
                    pass_q  <= 1'b0;
                    idx_q   <= '0;
                    state_q <= S_RD0;
                end
                S_RD0: if (rd_valid) begin
                    w0_q    <= rd_data;
                    state_q <= S_RD1;
                end
                S_RD1: if (rd_valid) begin
                    w1_q    <= rd_data;
                    state_q <= S_CHK;
                end
                S_CHK: begin
                    if (hit) begin
                        status_q  <= rt_allowed ? ST_OK : ST_PROT;
                        rpn_q     <= w1_q[31:PAGE_SHIFT];
                        rights_q  <= rt_rights;
                        wb_data_q <= rt_new_w1;
                        state_q   <= rt_wb ? S_WB : S_FIN;
                    end else if (idx_q != LAST_IDX) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_RD0;
                    end else if (!pass_q) begin
                        pass_q  <= 1'b1;
                        idx_q   <= '0;
                        state_q <= S_RD0;
                    end else begin
                        status_q <= ST_MISS;
                        rpn_q    <= '0;
                        rights_q <= '0;
                        state_q  <= S_FIN;
                    end
                end
                S_WB:    state_q <= S_FIN;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Port drive from the sequencer state.
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_FIN);
        rd_req     = (state_q == S_RD0) || (state_q == S_RD1);
        rd_addr    = ent_addr;
        wr_req     = (state_q == S_WB);
        wr_addr    = ent_addr;
        wr_data    = wb_data_q;
        status     = status_q;
        rpn_out    = rpn_q;
        rights_out = rights_q;
    end

    // R11: done lasts a single cycle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11: a search only begins after start.
    a_r11_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R8: every write-back carries the referenced bit.
    a_r8_wb_ref: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_data[REF_POS]);
    // R10: write-back targets word 1 of an entry.
    a_r10_wb_offset: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr[2:0] == 3'b100) && !rd_req);
    // R5: a miss reports no rights and no page.
    a_r5_miss_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_MISS) |-> (rights_out == 3'b000 && rpn_out == '0));
    // R9: a permitted write keeps the write right.
    a_r9_write_keeps_w: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_OK && kind_q == ACC_WRITE) |-> rights_out[1]);
endmodule

// File: tb/ptg_searcher_tb_top.sv
module ptg_searcher_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tag_in = '0;
    logic [18:0] hash_in = '0;
    logic [31:0] tbl_base = 32'h0010_0000;
    logic [31:0] tbl_mask = 32'h0000_FFC0;
    logic        key_in = 1'b0, nx_in = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic        busy, done, rd_req, wr_req;
    logic [1:0]  status;
    logic [19:0] rpn_out;
    logic [2:0]  rights_out;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;

    int checks = 0, errors = 0;
    logic [31:0] mem [logic [31:0]];
    int          wr_count = 0;
    logic        first_pending = 1'b0;
    logic [31:0] first_addr = '0;

    always #2 clk = ~clk;

    ptg_searcher dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tag_in(tag_in),
        .hash_in(hash_in), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
        .key_in(key_in), .nx_in(nx_in), .acc_kind(acc_kind),
        .busy(busy), .done(done), .status(status), .rpn_out(rpn_out),
        .rights_out(rights_out), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [31:0] mread(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] grp(input logic [18:0] h);
        return tbl_base + (({13'b0, h} << 6) & tbl_mask);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference search computed from the requirements.
    task automatic ref_search(output logic [1:0] st, output logic [19:0] rpn,
                              output logic [2:0] rt, output bit wb,
                              output logic [31:0] wa, output logic [31:0] wd);
        bit found = 0;
        logic [31:0] w0, w1, a;
        logic r, w, x, ok;
        st = 2'd1; rpn = '0; rt = '0; wb = 0; wa = '0; wd = '0;
        for (int p = 0; p < 2 && !found; p++) begin
            for (int i = 0; i < 8 && !found; i++) begin
                a  = grp(p == 0 ? hash_in : ~hash_in) + 32'(i * 8);
                w0 = mread(a);
                w1 = mread(a + 4);
                if (w0[31] && w0[6] == p[0] && (w0 & 32'h7FFF_FFBF) == tag_in) begin
                    found = 1;
                    r = !(key_in && w1[1:0] == 2'd0);
                    w = key_in ? (w1[1:0] == 2'd2) : (w1[1:0] != 2'd3);
                    x = !nx_in;
                    ok = (acc_kind == 2'd1) ? w : (acc_kind == 2'd2) ? x : r;
                    st = ok ? 2'd0 : 2'd2;
                    rpn = w1[31:12];
                    wd = w1 | 32'h100;
                    if (!w1[7]) begin
                        if (acc_kind == 2'd1 && ok) wd = wd | 32'h80;
                        else w = 1'b0;
                    end
                    rt = {x, w, r};
                    wb = (wd != w1);
                    wa = a + 4;
                end
            end
        end
    endtask

    task automatic put(input int p, input logic [18:0] h, input int slot,
                       input logic [31:0] w0, input logic [31:0] w1);
        logic [31:0] a = grp(p == 0 ? h : ~h) + 32'(slot * 8);
        mem[a] = w0;
        mem[a + 4] = w1;
    endtask

    // Run one search and check all results against the reference.
    task automatic run_search(input string tagname);
        logic [1:0] est; logic [19:0] erpn; logic [2:0] ert;
        bit ewb; logic [31:0] ewa, ewd;
        logic [1:0] s_st; logic [19:0] s_rpn; logic [2:0] s_rt;
        int n = 0;
        ref_search(est, erpn, ert, ewb, ewa, ewd);
        wr_count = 0;
        first_pending = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        if (!done) begin
            chk(0, {"R11 watchdog ", tagname}, 32'(n), 32'd2000);
            return;
        end
        chk(first_addr == grp(hash_in), {"R1 first read ", tagname}, first_addr, grp(hash_in));
        chk(status == est, {"R7 status ", tagname}, 32'(status), 32'(est));
        chk(rpn_out == erpn, {"R12 rpn ", tagname}, 32'(rpn_out), 32'(erpn));
        chk(rights_out == ert, {"R6 rights ", tagname}, 32'(rights_out), 32'(ert));
        chk(wr_count == (ewb ? 1 : 0), {"R10 write count ", tagname}, 32'(wr_count), 32'(ewb));
        if (ewb) chk(mread(ewa) == ewd, {"R8 word1 written ", tagname}, mread(ewa), ewd);
        s_st = status; s_rpn = rpn_out; s_rt = rights_out;
        repeat (3) @(negedge clk);
        chk(!busy && status == s_st && rpn_out == s_rpn && rights_out == s_rt,
            {"R11 hold ", tagname}, {27'b0, busy, status, s_rt[0], 1'b0}, {27'b0, 1'b0, s_st, s_rt[0], 1'b0});
    endtask

    // Memory model: random latency, one valid per request, writes applied.
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                rd_valid = 1'b0;
                lat = $urandom % 3;
            end else if (rd_req) begin
                if (first_pending) begin first_addr = rd_addr; first_pending = 1'b0; end
                if (lat == 0) begin rd_valid = 1'b1; rd_data = mread(rd_addr); end
                else lat--;
            end
            if (wr_req) begin mem[wr_addr] = wr_data; wr_count++; end
        end
    end

    initial begin
        logic [31:0] t;
        logic [31:0] ea;
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        chk(!busy && !done && !rd_req && !wr_req, "R11 reset state",
            {28'b0, busy, done, rd_req, wr_req}, 32'h0);

        // R2/R12: primary slot 7 hit; earlier slots fail one match rule each.
        mem.delete();
        t = 32'h1234_5680 | 32'h15; tag_in = t & 32'h7FFF_FFBF; hash_in = 19'h0_1234;
        key_in = 0; nx_in = 0; acc_kind = 2'd0;
        put(0, hash_in, 0, tag_in, 32'hAAAA_A002);
        put(0, hash_in, 1, tag_in | 32'h8000_0040, 32'hBBBB_B002);
        put(0, hash_in, 2, (tag_in ^ 32'h100) | 32'h8000_0000, 32'hCCCC_C002);
        put(0, hash_in, 7, tag_in | 32'h8000_0000, 32'h5555_5002);
        run_search("R2 slot7");
        chk(rpn_out == 20'h55555 && rights_out == 3'b101, "R9 read on clean page drops W",
            {9'b0, rights_out, rpn_out}, {9'b0, 3'b101, 20'h55555});

        // R4: secondary hit, permitted write sets changed bit.
        mem.delete(); acc_kind = 2'd1; hash_in = 19'h7_0F0F;
        put(0, hash_in, 3, tag_in | 32'h8000_0040, 32'h1111_1000);
        put(1, hash_in, 2, tag_in | 32'h8000_0040, 32'h2222_2000);
        run_search("R4 secondary");
        ea = grp(~hash_in) + 32'd20;
        chk(mread(ea) == 32'h2222_2180, "R9 changed bit set", mread(ea), 32'h2222_2180);

        // R3: two primary matches, first wins.
        mem.delete(); acc_kind = 2'd0;
        put(0, hash_in, 1, tag_in | 32'h8000_0000, 32'h3333_3180);
        put(0, hash_in, 4, tag_in | 32'h8000_0000, 32'h4444_4180);
        run_search("R3 first match");
        chk(rpn_out == 20'h33333 && wr_count == 0, "R3 slot1 rpn",
            32'(rpn_out), 32'h33333);

        // R5: nothing matches.
        mem.delete();
        put(1, hash_in, 0, tag_in | 32'h8000_0000, 32'h6666_6000);
        run_search("R5 miss");
        chk(status == 2'd1 && rights_out == 0, "R5 miss status", 32'(status), 32'd1);

        // R7/R8: key 1 pp 0 read faults but still marks referenced.
        mem.delete(); key_in = 1;
        put(0, hash_in, 0, tag_in | 32'h8000_0000, 32'h7777_7000);
        run_search("R7 key1 pp0");
        chk(status == 2'd2 && wr_count == 1, "R8 ref on fault",
            {30'b0, status}, 32'd2);

        // R6/R10: fetch with nx faults; flags already set so no write.
        mem.delete(); key_in = 0; nx_in = 1; acc_kind = 2'd2;
        put(0, hash_in, 5, tag_in | 32'h8000_0000, 32'h8888_8182);
        run_search("R6 nx fetch");
        chk(rights_out == 3'b011 && status == 2'd2 && wr_count == 0,
            "R10 no write when unchanged", {27'b0, status, rights_out}, {27'b0, 2'd2, 3'b011});

        // Random mix against the reference.
        for (int it = 0; it < 80; it++) begin
            mem.delete();
            tag_in  = ({8'b0, 24'($urandom)} << 7) | 32'($urandom % 64);
            hash_in = 19'($urandom);
            key_in  = 1'($urandom); nx_in = 1'($urandom);
            acc_kind = 2'($urandom % 3);
            for (int p = 0; p < 2; p++) begin
                for (int s = 0; s < 8; s++) begin
                    int r = $urandom % 12;
                    logic [31:0] w0;
                    case (r)
                        0: w0 = tag_in | 32'h8000_0000 | (p == 1 ? 32'h40 : 32'h0);
                        1: w0 = tag_in;
                        2: w0 = tag_in | 32'h8000_0000 | (p == 0 ? 32'h40 : 32'h0);
                        default: w0 = $urandom;
                    endcase
                    put(p, hash_in, s, w0, $urandom);
                end
            end
            run_search("R2 R4 R6 R7 R9 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run becomes a failed check.
    initial begin
        repeat (150000) @(negedge clk);
        checks++; errors++;
        $display("FAIL R11 watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule